// File: doc/BRIEF.md
# CPU Interrupt Interface with Priority Masking

This block sits between an interrupt distributor and one processor core. The distributor presents its best pending interrupt as an ID and an 8-bit priority, where a smaller number means more urgent. The block decides whether that interrupt may reach the core. To pass, it must beat the programmable priority mask. It must also beat the running priority, comparing only the group part that a programmable binary point selects. A small stack of nested running priorities lets higher-group interrupts preempt a handler that is already running.

Software reaches the block through a simple memory-mapped register port. Read data is combinational while the read strobe is high. Side effects take place at the clock edge that ends the access. Reading the acknowledge register takes the interrupt and sends an acknowledge pulse to the distributor. Writing end-of-interrupt drops the running priority. Deactivation is either combined with end-of-interrupt or done as a second step through a separate register.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset the control register reads 0, the priority mask reads 0x00, the binary point reads 2, the running priority reads 0xFF, and the identification register at 0x00FC reads 0x0202143B.
- R2: Control register 0x0000 uses bit 0 to enable signalling, bit 1 to select FIQ (1) or IRQ (0), and bit 2 for split deactivation. While bit 0 is 0, neither irqOut nor fiqOut is asserted, and the two outputs are never high together.
- R3: A pending interrupt qualifies only if its priority is numerically lower than the priority mask at 0x0004. A priority equal to the mask is held back.
- R4: When a handler is running, a pending interrupt also qualifies only if its group priority is strictly lower than the running group priority. The group part is bits [7:b+1] for binary point value b at 0x0008, so the default 2 compares bits [7:3] and the value 7 compares nothing.
- R5: Reading 0x000C while an interrupt qualifies returns its ID in bits [9:0]. The read pushes its priority onto the running stack. In the next cycle ackPulse is high with ackId equal to that ID.
- R6: When nothing qualifies, including when pendValid is low, reading 0x000C returns 1023. Such a read produces no acknowledge pulse and leaves the running priority unchanged.
- R7: Writing 0x0010 pops the running stack. When control bit 2 is 0, the same write also pulses deactPulse in the next cycle, with deactId equal to write data bits [9:0].
- R8: Writing 0x1000 pulses deactPulse in the next cycle with deactId equal to write data bits [9:0]. When control bit 2 is 1, a write to 0x0010 produces no deactivate pulse.
- R9: Register 0x0014 returns the priority of the most recently acknowledged interrupt that has not yet been ended. It returns 0xFF when the stack is empty.
- R10: Register 0x0018 returns the same value an acknowledge read would return, and reading it has no side effects.
- R11: The stack holds 4 entries. While it is full, nothing qualifies. After it is emptied, the running priority reads 0xFF again.
- R12: When read and write strobes are high in the same cycle, the write takes effect and the read is dropped, including its acknowledge side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 13 | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid while regRd is high |
| pendValid | input | 1 | Distributor has a pending candidate |
| pendId | input | 10 | Candidate interrupt ID |
| pendPrio | input | 8 | Candidate priority, lower is more urgent |
| irqOut | output | 1 | Interrupt request to the core |
| fiqOut | output | 1 | Fast interrupt request to the core |
| ackPulse | output | 1 | One-cycle acknowledge to the distributor |
| ackId | output | 10 | ID that was acknowledged |
| deactPulse | output | 1 | One-cycle deactivate to the distributor |
| deactId | output | 10 | ID to deactivate |

## Verification
The hardest state to reach is a full priority stack. Four acknowledges are needed, each with a strictly more urgent group than the one before. Only then does a fifth, even more urgent candidate become blocked. The bench walks the candidate down through four distinct group levels, acknowledging each one. It then presents a top-urgency candidate and expects a spurious ID, before unwinding with four end-of-interrupt writes. The binary-point effect is reached by holding a running priority and a candidate that share a group at the default split. Changing the split then makes the candidate preempt.

// File: rtl/irqcpu_pkg.sv
package irqcpu_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam logic [ID_W-1:0]   ID_NONE   = ID_W'(1023);
  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;
  localparam logic [31:0]       IFACE_ID  = 32'h0202_143B;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_PMR, SEL_BPR, SEL_ACK, SEL_RUN, SEL_HPP, SEL_IID
  } rdsel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrPmr;
    logic wrBpr;
    logic ackRd;
    logic eoiWr;
    logic dirWr;
  } strobe_t;
endpackage

// File: rtl/irqcpu_ctrl.sv
module irqcpu_ctrl
  import irqcpu_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  output strobe_t           stb,
  output rdsel_e            rdSel
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(13'h0000);
  localparam logic [ADDR_W-1:0] OFF_PMR  = ADDR_W'(13'h0004);
  localparam logic [ADDR_W-1:0] OFF_BPR  = ADDR_W'(13'h0008);
  localparam logic [ADDR_W-1:0] OFF_ACK  = ADDR_W'(13'h000C);
  localparam logic [ADDR_W-1:0] OFF_EOI  = ADDR_W'(13'h0010);
  localparam logic [ADDR_W-1:0] OFF_RUN  = ADDR_W'(13'h0014);
  localparam logic [ADDR_W-1:0] OFF_HPP  = ADDR_W'(13'h0018);
  localparam logic [ADDR_W-1:0] OFF_IID  = ADDR_W'(13'h00FC);
  localparam logic [ADDR_W-1:0] OFF_DIR  = ADDR_W'(13'h1000);

  logic rdLive;
  assign rdLive = regRd && !regWr;  // write wins (R12)

  always_comb begin
    stb   = '0;
    rdSel = SEL_NONE;
    if (regWr) begin
      case (regAddr)
        OFF_CTRL: stb.wrCtrl = 1'b1;
        OFF_PMR:  stb.wrPmr  = 1'b1;
        OFF_BPR:  stb.wrBpr  = 1'b1;
        OFF_EOI:  stb.eoiWr  = 1'b1;
        OFF_DIR:  stb.dirWr  = 1'b1;
        default: ;
      endcase
    end
    if (rdLive) begin
      case (regAddr)
        OFF_CTRL: rdSel = SEL_CTRL;
        OFF_PMR:  rdSel = SEL_PMR;
        OFF_BPR:  rdSel = SEL_BPR;
        OFF_ACK: begin
          rdSel     = SEL_ACK;
          stb.ackRd = 1'b1;
        end
        OFF_RUN:  rdSel = SEL_RUN;
        OFF_HPP:  rdSel = SEL_HPP;
        OFF_IID:  rdSel = SEL_IID;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqcpu_dp.sv
module irqcpu_dp
  import irqcpu_pkg::*;
#(
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  rdsel_e            rdSel,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              pendValid,
  input  logic [ID_W-1:0]   pendId,
  input  logic [PRIO_W-1:0] pendPrio,
  output logic              irqOut,
  output logic              fiqOut,
  output logic              ackPulse,
  output logic [ID_W-1:0]   ackId,
  output logic              deactPulse,
  output logic [ID_W-1:0]   deactId
);
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W   = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic [2:0]        ctrlReg;   // bit0 enable, bit1 fiq, bit2 split
  logic [PRIO_W-1:0] pmrReg;
  logic [2:0]        bprReg;
  logic [PRIO_W-1:0] prioStack [STACK_DEPTH];
  logic [DEPTH_W-1:0] depth;

  logic [DEPTH_W-1:0] topIdx;
  logic [PRIO_W-1:0]  runPrio;
  logic [PRIO_W:0]    grpWide;
  logic [PRIO_W-1:0]  grpMask;
  logic               qualify;
  logic [ID_W-1:0]    bestId;
  logic               unusedBits;

  assign unusedBits = ^wrData[31:ID_W];
  assign topIdx  = depth - DEPTH_W'(1);
  assign runPrio = (depth == '0) ? PRIO_IDLE : prioStack[topIdx[IDX_W-1:0]];
  assign grpWide = {(PRIO_W+1){1'b1}} << (4'(bprReg) + 4'd1);
  assign grpMask = grpWide[PRIO_W-1:0];

  assign qualify = pendValid && (pendPrio < pmrReg)
                && (depth < DEPTH_W'(STACK_DEPTH))
                && ((depth == '0) || ((pendPrio & grpMask) < (runPrio & grpMask)));
  assign bestId  = qualify ? pendId : ID_NONE;

  assign irqOut = ctrlReg[0] && qualify && !ctrlReg[1];
  assign fiqOut = ctrlReg[0] && qualify &&  ctrlReg[1];

  always_comb begin
    case (rdSel)
      SEL_CTRL: rdData = {29'd0, ctrlReg};
      SEL_PMR:  rdData = {24'd0, pmrReg};
      SEL_BPR:  rdData = {29'd0, bprReg};
      SEL_ACK,
      SEL_HPP:  rdData = {{(32-ID_W){1'b0}}, bestId};
      SEL_RUN:  rdData = {24'd0, runPrio};
      SEL_IID:  rdData = IFACE_ID;
      default:  rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      pmrReg     <= '0;
      bprReg     <= 3'd2;
      depth      <= '0;
      ackPulse   <= 1'b0;
      ackId      <= '0;
      deactPulse <= 1'b0;
      deactId    <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) prioStack[i] <= PRIO_IDLE;
    end else begin
      ackPulse   <= 1'b0;
      deactPulse <= 1'b0;
      if (stb.wrCtrl) ctrlReg <= wrData[2:0];
      if (stb.wrPmr)  pmrReg  <= wrData[PRIO_W-1:0];
      if (stb.wrBpr)  bprReg  <= wrData[2:0];
      if (stb.ackRd && qualify) begin
        prioStack[depth[IDX_W-1:0]] <= pendPrio;
        depth    <= depth + DEPTH_W'(1);
        ackPulse <= 1'b1;
        ackId    <= pendId;
      end
      if (stb.eoiWr) begin
        if (depth != '0) depth <= depth - DEPTH_W'(1);
        if (!ctrlReg[2]) begin
          deactPulse <= 1'b1;
          deactId    <= wrData[ID_W-1:0];
        end
      end
      if (stb.dirWr) begin
        deactPulse <= 1'b1;
        deactId    <= wrData[ID_W-1:0];
      end
    end
  end

  p_one_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && fiqOut));
  p_below_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut || fiqOut) |-> (pendPrio < pmrReg));
  p_ack_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (depth == DEPTH_W'($past(depth) + DEPTH_W'(1))));
  p_eoi_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoiWr && depth != '0) |=> (depth == DEPTH_W'($past(depth) - DEPTH_W'(1))));
  p_stack_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEPTH_W'(STACK_DEPTH));
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irqcpu_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              pendValid,
  input  logic [ID_W-1:0]   pendId,
  input  logic [PRIO_W-1:0] pendPrio,
  output logic              irqOut,
  output logic              fiqOut,
  output logic              ackPulse,
  output logic [ID_W-1:0]   ackId,
  output logic              deactPulse,
  output logic [ID_W-1:0]   deactId
);
  strobe_t stb;
  rdsel_e  rdSel;

  irqcpu_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .stb(stb), .rdSel(rdSel)
  );

  irqcpu_dp #(.STACK_DEPTH(STACK_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel),
    .wrData(regWrData), .rdData(regRdData),
    .pendValid(pendValid), .pendId(pendId), .pendPrio(pendPrio),
    .irqOut(irqOut), .fiqOut(fiqOut),
    .ackPulse(ackPulse), .ackId(ackId),
    .deactPulse(deactPulse), .deactId(deactId)
  );
endmodule

// File: tb/irq_cpu_port_tb.sv
`timescale 1ns/1ps
module irq_cpu_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pendValid = 1'b0;
  logic [9:0]  pendId = '0;
  logic [7:0]  pendPrio = '0;
  logic        irqOut, fiqOut, ackPulse, deactPulse;
  logic [9:0]  ackId, deactId;

  int checks = 0, fails = 0;
  logic [31:0] rdVal;
  logic        sawAck, sawDeact;
  logic [9:0]  sawAckId, sawDeactId;

  always #2.5 clk = ~clk;

  irq_cpu_port dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData),
    .pendValid(pendValid), .pendId(pendId), .pendPrio(pendPrio),
    .irqOut(irqOut), .fiqOut(fiqOut), .ackPulse(ackPulse), .ackId(ackId),
    .deactPulse(deactPulse), .deactId(deactId)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [12:0] a);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 rdVal = regRdData;
    @(negedge clk);
    regRd = 1'b0;
    #1 sawAck = ackPulse; sawAckId = ackId;
  endtask

  task automatic writeReg(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
    #1 sawDeact = deactPulse; sawDeactId = deactId;
  endtask

  task automatic setPend(input logic v, input logic [9:0] id, input logic [7:0] p);
    @(negedge clk);
    pendValid = v; pendId = id; pendPrio = p;
    #1;
  endtask

  task automatic testReset();
    readReg(13'h0000); chk("R1 ctrl", rdVal, 0);
    readReg(13'h0004); chk("R1 mask", rdVal, 0);
    readReg(13'h0008); chk("R1 bpr", rdVal, 2);
    readReg(13'h0014); chk("R1 rpr", rdVal, 32'hFF);
    readReg(13'h00FC); chk("R1 id", rdVal, 32'h0202143B);
    chk("R1 irq low", {irqOut, fiqOut}, 0);
  endtask

  task automatic testMask();
    writeReg(13'h0000, 1); writeReg(13'h0004, 32'h80);
    setPend(1, 5, 8'h80); chk("R3 equal held", irqOut, 0);
    setPend(1, 5, 8'h7F); chk("R3 below passes", irqOut, 1);
    chk("R2 irq not fiq", fiqOut, 0);
    writeReg(13'h0000, 3); #1 chk("R2 fiq select", {irqOut, fiqOut}, 2'b01);
    writeReg(13'h0000, 0); #1 chk("R2 disabled", {irqOut, fiqOut}, 2'b00);
  endtask

  task automatic testAck();
    writeReg(13'h0000, 1); writeReg(13'h0004, 32'hF0);
    setPend(1, 42, 8'h44);
    readReg(13'h0018); chk("R10 hpp id", rdVal, 42);
    chk("R10 no ack", sawAck, 0);
    readReg(13'h0014); chk("R10 rpr unchanged", rdVal, 32'hFF);
    readReg(13'h000C); chk("R5 ack id read", rdVal, 42);
    chk("R5 ack pulse", {sawAck, sawAckId}, {1'b1, 10'd42});
    readReg(13'h0014); chk("R9 rpr", rdVal, 32'h44);
  endtask

  task automatic testPreempt();
    setPend(1, 43, 8'h42); chk("R4 same group held", irqOut, 0);
    readReg(13'h000C); chk("R6 spurious", rdVal, 1023);
    chk("R6 no pulse", sawAck, 0);
    readReg(13'h0014); chk("R6 rpr kept", rdVal, 32'h44);
    writeReg(13'h0008, 0); #1 chk("R4 finer split preempts", irqOut, 1);
    writeReg(13'h0008, 7); #1 chk("R4 no group bits", irqOut, 0);
    writeReg(13'h0008, 2);
  endtask

  task automatic testEoi();
    writeReg(13'h0010, 42);
    chk("R7 deact on eoi", {sawDeact, sawDeactId}, {1'b1, 10'd42});
    readReg(13'h0014); chk("R7 rpr dropped", rdVal, 32'hFF);
  endtask

  task automatic testSplit();
    writeReg(13'h0000, 5);
    setPend(1, 43, 8'h42);
    readReg(13'h000C); chk("R5 ack 43", rdVal, 43);
    writeReg(13'h0010, 43); chk("R8 split no deact", sawDeact, 0);
    readReg(13'h0014); chk("R7 split rpr dropped", rdVal, 32'hFF);
    writeReg(13'h1000, 43);
    chk("R8 dir deact", {sawDeact, sawDeactId}, {1'b1, 10'd43});
  endtask

  task automatic testFull();
    writeReg(13'h0000, 1);
    for (int i = 0; i < 4; i++) begin
      setPend(1, 10'(i + 1), 8'(8'h70 - 8'(i) * 8'h10));
      readReg(13'h000C); chk("R11 nested ack", rdVal, i + 1);
    end
    readReg(13'h0014); chk("R11 rpr top", rdVal, 32'h40);
    setPend(1, 9, 8'h10); chk("R11 full blocks", irqOut, 0);
    readReg(13'h000C); chk("R11 full spurious", rdVal, 1023);
    for (int i = 0; i < 4; i++) writeReg(13'h0010, 32'(4 - i));
    readReg(13'h0014); chk("R11 emptied", rdVal, 32'hFF);
    chk("R11 irq after unwind", irqOut, 1);
  endtask

  task automatic testNoPend();
    setPend(0, 7, 8'h10);
    readReg(13'h000C); chk("R6 no valid spurious", rdVal, 1023);
    readReg(13'h0018); chk("R6 hpp spurious", rdVal, 1023);
  endtask

  task automatic testCollide();
    setPend(1, 11, 8'h20);
    @(negedge clk);
    regAddr = 13'h000C; regRd = 1'b1; regWr = 1'b1; regWrData = 0;
    @(negedge clk);
    regRd = 1'b0; regWr = 1'b0;
    #1 chk("R12 read dropped", ackPulse, 0);
    readReg(13'h0014); chk("R12 rpr idle", rdVal, 32'hFF);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMask();
    testAck();
    testPreempt();
    testEoi();
    testSplit();
    testFull();
    testNoPend();
    testCollide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule